// File: doc/BRIEF.md
# Pseudo-static RAM page-mode controller

This block sits between a synchronous host and an external 16-bit pseudo-static RAM that is driven with asynchronous SRAM-style strobes. The host hands over one request at a time through a valid/ready handshake. A request carries a word address, a direction, two byte-lane enables and a burst length of one to eight words. The controller turns each request into one chip-enable window on the memory side. It shapes every strobe in whole clock cycles. The cycle counts come from the clock period and the memory's minimum times, all of them parameters.

A burst stays inside one eight-word page. The first word gets a full-length cycle. Every further word changes only the three low address bits and uses the shorter page cycle, for reads and for writes. Write data is pulled from the host one word at a time through a take pulse. Read data comes back one word at a time with a one-cycle valid pulse. Between two requests the chip enable always returns high. The length of one window is limited to 10 µs by elaboration checks on the parameters, and a run-time bound watches it as well.

Top module: `psram_page_ctrl`

## Requirements
- R1: While reset is held and directly after it, mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n and mem_ub_n are high. mem_dq_oe and rd_valid are low, and req_ready is high.
- R2: A request is taken on a clock edge where req_valid and req_ready are both high. req_ready stays low until that request has finished. Each request opens exactly one chip-enable window, and mem_ce_n stays high for at least two cycles after every window.
- R3: A read holds its first word address for ceil(70 ns / CLK_NS) cycles and each later word for ceil(25 ns / CLK_NS) cycles. mem_dq_in is sampled on the last edge of each word. rd_valid then pulses for one cycle with that word on rd_data, once per word.
- R4: Word i of a burst (i = 0 to req_len, where req_len = words - 1) uses the address {req_addr[22:3], (req_addr[2:0] + i) mod 8}. Bits 22..3 never change inside a window.
- R5: A single write, or the first word of a page write, drives mem_we_n low from the first cycle of the word for ceil(50 ns / CLK_NS) cycles. The word lasts max(ceil(70 ns / CLK_NS), low cycles + ceil(10 ns / CLK_NS)) cycles.
- R6: Each later word of a page write drives mem_we_n low for ceil(15 ns / CLK_NS) cycles. The word lasts max(ceil(30 ns / CLK_NS), low cycles + ceil(10 ns / CLK_NS)) cycles.
- R7: During a write window mem_oe_n is high and mem_dq_oe is high for the whole window. During a read window mem_oe_n is low and mem_dq_oe is low.
- R8: req_be[0] selects the lower byte (mem_lb_n low) and req_be[1] the upper byte (mem_ub_n low), held for the whole window. A write with one lane enabled leaves the other byte of each word unchanged.
- R9: wdata_take pulses once per written word, on the edge where req_wdata is latched. The first pulse is on the accepting edge. mem_dq_out stays constant while mem_we_n is low.
- R10: One chip-enable window lasts at most ceil(10 µs / CLK_NS) cycles. With the default parameters, the longest window of eight words stays below this limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address of the first word |
| req_len | input | 3 | Number of words minus one |
| req_be | input | 2 | Byte-lane enables: bit 0 lower, bit 1 upper |
| req_wdata | input | 16 | Write word currently offered |
| wdata_take | output | 1 | The offered write word is latched on this edge |
| rd_valid | output | 1 | One-cycle pulse: rd_data holds a read word |
| rd_data | output | 16 | Read word |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_lb_n | output | 1 | Lower byte strobe, active low |
| mem_ub_n | output | 1 | Upper byte strobe, active low |
| mem_addr | output | 23 | Memory word address |
| mem_dq_out | output | 16 | Data driven toward the memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 16 | Data returned by the memory |

## Verification
A beat counter that is off by even one cycle shows up at the latest when the address next changes. The hold time of the address, or the low time of mem_we_n, then differs from the computed count. On a read, the sample is also taken before the model's access time has passed, so rd_data carries a marker value. A wrong word index shows within one word time as a low-bit address step other than +1, or at the end of the request as a wrong number of rd_valid or wdata_take pulses. A corrupt state or lane register shows inside the first cycle of a window, in mem_oe_n, mem_dq_oe or the byte strobes. Byte-lane faults also show in later read-back of words written with one lane.

// File: rtl/psram_pkg.sv
`timescale 1ns/1ps
package psram_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_RD,
      ST_WR,
      ST_GAP
   } ctrl_state_e;

   // whole clock cycles covering a minimum time, never less than one
   function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
      int unsigned c;
      c = (ns + period - 1) / period;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/psram_beat_timer.sv
`timescale 1ns/1ps
module psram_beat_timer #(
   parameter int unsigned CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] beat_len,
   input  logic [CNT_W-1:0] low_len,
   output logic             low_phase,
   output logic             beat_end
);

   logic [CNT_W-1:0] cnt_q;

   assign beat_end  = run && (cnt_q == beat_len - CNT_W'(1));
   assign low_phase = run && (cnt_q < low_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || beat_end)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end

   // R5: the position inside a word never passes the length chosen for it
   a_r5_cnt_in_beat: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q < beat_len));

   // R6: the strobe low phase is shorter than the word it sits in
   a_r6_low_shorter: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (low_len < beat_len));

endmodule

// File: rtl/psram_page_addr.sv
`timescale 1ns/1ps
module psram_page_addr #(
   parameter int unsigned ADDR_W = 23,
   parameter int unsigned PAGE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   input  logic [ADDR_W-1:0] base,
   input  logic [PAGE_W-1:0] len,
   output logic [ADDR_W-1:0] word_addr,
   output logic              first,
   output logic              last
);

   localparam int unsigned HI_W = ADDR_W - PAGE_W;

   logic [HI_W-1:0]   hi_q;
   logic [PAGE_W-1:0] lo_q, idx_q, len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         idx_q <= '0;
         len_q <= '0;
      end else if (load) begin
         hi_q  <= base[ADDR_W-1:PAGE_W];
         lo_q  <= base[PAGE_W-1:0];
         idx_q <= '0;
         len_q <= len;
      end else if (advance) begin
         lo_q  <= lo_q + PAGE_W'(1);
         idx_q <= idx_q + PAGE_W'(1);
      end
   end

   assign word_addr = {hi_q, lo_q};
   assign first     = (idx_q == '0);
   assign last      = (idx_q == len_q);

   // R4: the sequencer never steps beyond the requested word count
   a_r4_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= len_q);

endmodule

// File: rtl/psram_page_ctrl.sv
`timescale 1ns/1ps
module psram_page_ctrl
   import psram_pkg::*;
#(
   parameter int unsigned CLK_NS       = 8,
   parameter int unsigned ADDR_W       = 23,
   parameter int unsigned DATA_W       = 16,
   parameter int unsigned PAGE_W       = 3,
   parameter int unsigned T_RC_NS      = 70,
   parameter int unsigned T_PAGE_NS    = 25,
   parameter int unsigned T_WC_NS      = 70,
   parameter int unsigned T_WP_NS      = 50,
   parameter int unsigned T_DS_NS      = 30,
   parameter int unsigned T_PWC1_NS    = 70,
   parameter int unsigned T_PWC2_NS    = 30,
   parameter int unsigned T_WPPM_NS    = 15,
   parameter int unsigned T_WHP_NS     = 10,
   parameter int unsigned T_ACT_MAX_NS = 10000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   output logic                req_ready,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [PAGE_W-1:0]   req_len,
   input  logic [DATA_W/8-1:0] req_be,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                wdata_take,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   output logic                mem_ce_n,
   output logic                mem_oe_n,
   output logic                mem_we_n,
   output logic                mem_lb_n,
   output logic                mem_ub_n,
   output logic [ADDR_W-1:0]   mem_addr,
   output logic [DATA_W-1:0]   mem_dq_out,
   output logic                mem_dq_oe,
   input  logic [DATA_W-1:0]   mem_dq_in
);

   localparam int unsigned LANES     = DATA_W / 8;
   localparam int unsigned BURST_MAX = 1 << PAGE_W;
   localparam int unsigned RC_C      = ns_to_cyc(T_RC_NS, CLK_NS);
   localparam int unsigned PAGE_C    = ns_to_cyc(T_PAGE_NS, CLK_NS);
   localparam int unsigned WP_C      = ns_to_cyc(T_WP_NS, CLK_NS);
   localparam int unsigned DS_C      = ns_to_cyc(T_DS_NS, CLK_NS);
   localparam int unsigned WPPM_C    = ns_to_cyc(T_WPPM_NS, CLK_NS);
   localparam int unsigned WHP_C     = ns_to_cyc(T_WHP_NS, CLK_NS);
   localparam int unsigned WF_C      = max2(max2(ns_to_cyc(T_WC_NS, CLK_NS),
                                                 ns_to_cyc(T_PWC1_NS, CLK_NS)), WP_C + WHP_C);
   localparam int unsigned WPG_C     = max2(ns_to_cyc(T_PWC2_NS, CLK_NS), WPPM_C + WHP_C);
   localparam int unsigned ACT_C     = ns_to_cyc(T_ACT_MAX_NS, CLK_NS);
   localparam int unsigned BEAT_MAX  = max2(max2(RC_C, PAGE_C), max2(WF_C, WPG_C));
   localparam int unsigned CNT_W     = $clog2(BEAT_MAX + 1);
   localparam int unsigned ACT_W     = $clog2(ACT_C + 1);
   localparam int unsigned RD_SPAN   = RC_C + (BURST_MAX - 1) * PAGE_C;
   localparam int unsigned WR_SPAN   = WF_C + (BURST_MAX - 1) * WPG_C;

   localparam logic [CNT_W-1:0] RC_L   = CNT_W'(RC_C);
   localparam logic [CNT_W-1:0] PAGE_L = CNT_W'(PAGE_C);
   localparam logic [CNT_W-1:0] WF_L   = CNT_W'(WF_C);
   localparam logic [CNT_W-1:0] WPG_L  = CNT_W'(WPG_C);
   localparam logic [CNT_W-1:0] WP_L   = CNT_W'(WP_C);
   localparam logic [CNT_W-1:0] WPPM_L = CNT_W'(WPPM_C);

   // elaboration-time parameter checks
   if (DATA_W != 16) begin : g_bad_width
      $error("psram_page_ctrl: the memory word must be 16 bits");
   end
   if (PAGE_W < 1 || PAGE_W > 4 || ADDR_W <= PAGE_W) begin : g_bad_page
      $error("psram_page_ctrl: page width out of range");
   end
   if (RD_SPAN >= ACT_C || WR_SPAN >= ACT_C) begin : g_bad_span
      $error("psram_page_ctrl: longest burst exceeds the active-time limit");
   end
   if (WP_C < DS_C) begin : g_bad_setup
      $error("psram_page_ctrl: write pulse shorter than data set-up");
   end

   ctrl_state_e        state_q, state_d;
   logic [LANES-1:0]   be_q, lane_n;
   logic [DATA_W-1:0]  wd_q, rd_q;
   logic               rdv_q;
   logic [ACT_W-1:0]   act_q;
   logic               in_rd, in_wr, run, accept, advance;
   logic               beat_end, low_phase, first, last;
   logic [CNT_W-1:0]   beat_len, low_len;
   logic [ADDR_W-1:0]  word_addr;

   assign in_rd   = (state_q == ST_RD);
   assign in_wr   = (state_q == ST_WR);
   assign run     = in_rd || in_wr;
   assign accept  = (state_q == ST_IDLE) && req_valid;
   assign advance = beat_end && !last;

   always_comb begin
      if (in_wr) begin
         beat_len = first ? WF_L : WPG_L;
         low_len  = first ? WP_L : WPPM_L;
      end else begin
         beat_len = first ? RC_L : PAGE_L;
         low_len  = '0;
      end
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept) state_d = req_write ? ST_WR : ST_RD;
         ST_RD,
         ST_WR:   if (beat_end && last) state_d = ST_GAP;
         ST_GAP:  state_d = ST_IDLE;
         default: state_d = ST_IDLE;
      endcase
   end

   assign wdata_take = (accept && req_write) || (in_wr && advance);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         be_q    <= '0;
         wd_q    <= '0;
         rd_q    <= '0;
         rdv_q   <= 1'b0;
         act_q   <= '0;
      end else begin
         state_q <= state_d;
         if (accept)
            be_q <= req_be;
         if (wdata_take)
            wd_q <= req_wdata;
         rdv_q <= in_rd && beat_end;
         if (in_rd && beat_end)
            rd_q <= mem_dq_in;
         if (!run)
            act_q <= '0;
         else if (act_q != ACT_W'(ACT_C))
            act_q <= act_q + ACT_W'(1);
      end
   end

   psram_beat_timer #(
      .CNT_W (CNT_W)
   ) i_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .beat_len  (beat_len),
      .low_len   (low_len),
      .low_phase (low_phase),
      .beat_end  (beat_end)
   );

   psram_page_addr #(
      .ADDR_W (ADDR_W),
      .PAGE_W (PAGE_W)
   ) i_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .advance   (advance),
      .base      (req_addr),
      .len       (req_len),
      .word_addr (word_addr),
      .first     (first),
      .last      (last)
   );

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign lane_n[g] = !(run && be_q[g]);
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign rd_valid   = rdv_q;
   assign rd_data    = rd_q;
   assign mem_ce_n   = !run;
   assign mem_oe_n   = !in_rd;
   assign mem_we_n   = !(in_wr && low_phase);
   assign mem_lb_n   = lane_n[0];
   assign mem_ub_n   = lane_n[LANES-1];
   assign mem_addr   = word_addr;
   assign mem_dq_out = wd_q;
   assign mem_dq_oe  = in_wr;

   // R7: the memory output is never enabled while a write strobe is active
   a_r7_oe_off_in_write: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_we_n |-> (mem_oe_n && mem_dq_oe));

   // R2: a ready controller holds the memory deselected
   a_r2_ready_ce_high: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_ce_n);

   // R2: after a window the enable stays high for a second cycle
   a_r2_gap_after: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_ce_n) |=> mem_ce_n);

   // R4: only the low address bits move inside one window
   a_r4_page_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |->
      (mem_addr[ADDR_W-1:PAGE_W] == $past(mem_addr[ADDR_W-1:PAGE_W])));

   // R8: lane strobes do not move inside a window
   a_r8_lanes_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_ce_n && $past(!mem_ce_n)) |-> $stable({mem_lb_n, mem_ub_n}));

   // R9: write data is steady while the strobe is low
   a_r9_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_dq_out));

   // R3: a read word is only returned after a read window cycle
   a_r3_valid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(!mem_oe_n));

   // R10: the active window stays under the device limit
   a_r10_active_bound: assert property (@(posedge clk) disable iff (!rst_n)
      act_q < ACT_W'(ACT_C));

endmodule

// File: tb/test_psram_page_ctrl.sv
`timescale 1ns/1ps
module test_psram_page_ctrl;

   localparam int CLK_NS = 8;
   localparam int AW     = 23;
   localparam int RC_C   = (70 + CLK_NS - 1) / CLK_NS;
   localparam int PAGE_C = (25 + CLK_NS - 1) / CLK_NS;
   localparam int WC_C   = (70 + CLK_NS - 1) / CLK_NS;
   localparam int WP_C   = (50 + CLK_NS - 1) / CLK_NS;
   localparam int PWC2_C = (30 + CLK_NS - 1) / CLK_NS;
   localparam int WPPM_C = (15 + CLK_NS - 1) / CLK_NS;
   localparam int WHP_C  = (10 + CLK_NS - 1) / CLK_NS;
   localparam int ACT_C  = (10000 + CLK_NS - 1) / CLK_NS;
   localparam int WF_C   = (WC_C > WP_C + WHP_C) ? WC_C : WP_C + WHP_C;
   localparam int WPG_C  = (PWC2_C > WPPM_C + WHP_C) ? PWC2_C : WPPM_C + WHP_C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_NS / 2) clk = ~clk;

   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr  = '0;
   logic [2:0]    req_len   = '0;
   logic [1:0]    req_be    = '0;
   logic [15:0]   req_wdata;
   logic          req_ready, wdata_take, rd_valid;
   logic [15:0]   rd_data, mem_dq_out;
   logic          mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [15:0]   mem_dq_in = 16'h0;

   psram_page_ctrl i_psram_page_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .req_write  (req_write),
      .req_addr   (req_addr),
      .req_len    (req_len),
      .req_be     (req_be),
      .req_wdata  (req_wdata),
      .wdata_take (wdata_take),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .mem_ce_n   (mem_ce_n),
      .mem_oe_n   (mem_oe_n),
      .mem_we_n   (mem_we_n),
      .mem_lb_n   (mem_lb_n),
      .mem_ub_n   (mem_ub_n),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .mem_dq_oe  (mem_dq_oe),
      .mem_dq_in  (mem_dq_in)
   );

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // host-side write data source
   logic [15:0] wbuf [0:7];
   logic [7:0]  wptr = 8'd0;
   logic [7:0]  wstart = 8'd0;
   assign req_wdata = wbuf[3'(wptr - wstart)];
   always @(posedge clk) if (wdata_take) wptr <= wptr + 8'd1;

   // memory model and expectations
   logic [15:0] mem    [0:127];
   logic [15:0] shadow [0:127];
   logic [15:0] exp_rd [0:7];
   bit          cur_wr;
   int          cur_len;
   logic [1:0]  cur_be;
   int          rd_total = 0;
   int          rstart = 0;
   int          ce_falls = 0;

   bit            m_prev_ce_n = 1'b1;
   bit            m_prev_we_n = 1'b1;
   logic [AW-1:0] m_prev_addr = '0;
   int            hold, we_cnt, span;
   bit            b_first, b_wr;
   logic [15:0]   w_hold;

   task automatic close_beat();
      int eh;
      int el;
      eh = b_wr ? (b_first ? WF_C : WPG_C) : (b_first ? RC_C : PAGE_C);
      if (b_wr) chk(hold == eh, b_first ? "R5 write word length" : "R6 page write word length", hold, eh);
      else      chk(hold == eh, "R3 read word length", hold, eh);
      chk(b_wr == cur_wr, "R7 strobe kind matches request", b_wr, cur_wr);
      if (b_wr) begin
         el = b_first ? WP_C : WPPM_C;
         chk(we_cnt == el, b_first ? "R5 write low cycles" : "R6 page write low cycles", we_cnt, el);
      end
   endtask

   always @(negedge clk) begin
      if (!rst_n) begin
         m_prev_ce_n = 1'b1;
         m_prev_we_n = 1'b1;
         mem_dq_in   = 16'h0;
      end else begin
         if (!mem_ce_n) begin
            if (m_prev_ce_n) begin
               hold = 1; b_first = 1'b1; b_wr = 1'b0; we_cnt = 0; span = 1;
               ce_falls++;
            end else begin
               span++;
               if (mem_addr != m_prev_addr) begin
                  close_beat();
                  chk(mem_addr[AW-1:3] == m_prev_addr[AW-1:3], "R4 upper address fixed",
                      32'(mem_addr[AW-1:3]), 32'(m_prev_addr[AW-1:3]));
                  chk(mem_addr[2:0] == 3'(m_prev_addr[2:0] + 3'd1), "R4 low address step",
                      32'(mem_addr[2:0]), 32'(3'(m_prev_addr[2:0] + 3'd1)));
                  hold = 1; b_first = 1'b0; b_wr = 1'b0; we_cnt = 0;
               end else begin
                  hold++;
               end
            end
            chk({mem_lb_n, mem_ub_n} == {~cur_be[0], ~cur_be[1]}, "R8 lane strobes",
                32'({mem_lb_n, mem_ub_n}), 32'({~cur_be[0], ~cur_be[1]}));
            chk({mem_oe_n, mem_dq_oe} == {cur_wr, cur_wr}, "R7 output enable and bus direction",
                32'({mem_oe_n, mem_dq_oe}), 32'({cur_wr, cur_wr}));
            if (!mem_we_n) begin
               if (m_prev_we_n) w_hold = mem_dq_out;
               else chk(mem_dq_out == w_hold, "R9 write data steady", mem_dq_out, w_hold);
               we_cnt++;
               b_wr = 1'b1;
            end
            if (!m_prev_we_n && mem_we_n) begin
               if (!mem_lb_n) mem[mem_addr[6:0]][7:0]  = mem_dq_out[7:0];
               if (!mem_ub_n) mem[mem_addr[6:0]][15:8] = mem_dq_out[15:8];
            end
            if (!mem_oe_n && hold >= (b_first ? RC_C : PAGE_C))
               mem_dq_in = mem[mem_addr[6:0]];
            else
               mem_dq_in = 16'hBAD0;
         end else begin
            mem_dq_in = 16'hBAD0;
            if (!m_prev_ce_n) begin
               close_beat();
               if (cur_wr) chk(span == WF_C + cur_len * WPG_C, "R6 write window length", span, WF_C + cur_len * WPG_C);
               else        chk(span == RC_C + cur_len * PAGE_C, "R3 read window length", span, RC_C + cur_len * PAGE_C);
               chk(span <= ACT_C, "R10 active window bound", span, ACT_C);
            end
         end
         if (rd_valid) begin
            int k;
            k = rd_total - rstart;
            chk(k <= cur_len && rd_data == exp_rd[k[2:0]], "R3 read word value", rd_data, exp_rd[k[2:0]]);
            rd_total++;
         end
         m_prev_ce_n = mem_ce_n;
         m_prev_we_n = mem_we_n;
         m_prev_addr = mem_addr;
      end
   end

   task automatic xact(input bit wr, input logic [AW-1:0] a, input int len, input logic [1:0] be);
      int f0;
      @(negedge clk);
      cur_wr = wr; cur_len = len; cur_be = be;
      rstart = rd_total; wstart = wptr; f0 = ce_falls;
      for (int i = 0; i < 8; i++) begin
         logic [6:0] ix;
         ix = {a[6:3], 3'(a[2:0] + 3'(i))};
         wbuf[i] = 16'(int'(a[15:0]) * 37 + i * 4099 + len * 251 + 16'h1357);
         exp_rd[i] = shadow[ix];
         if (wr && i <= len) begin
            if (be[0]) shadow[ix][7:0]  = wbuf[i][7:0];
            if (be[1]) shadow[ix][15:8] = wbuf[i][15:8];
         end
      end
      req_write = wr; req_addr = a; req_len = 3'(len); req_be = be; req_valid = 1'b1;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(req_ready == 1'b0, "R2 ready low while busy", req_ready, 0);
      while (!req_ready) @(negedge clk);
      if (wr) chk(int'(8'(wptr - wstart)) == len + 1, "R9 take pulses per write", 8'(wptr - wstart), len + 1);
      else    chk(rd_total - rstart == len + 1, "R3 valid pulses per read", rd_total - rstart, len + 1);
      chk(ce_falls == f0 + 1, "R2 one enable window per request", ce_falls - f0, 1);
   endtask

   initial begin
      for (int i = 0; i < 128; i++) begin
         mem[i]    = 16'(i * 16'h0101) ^ 16'hA5C3;
         shadow[i] = 16'(i * 16'h0101) ^ 16'hA5C3;
      end
      cur_wr = 1'b0; cur_len = 0; cur_be = 2'b00;
      repeat (3) @(negedge clk);
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rd_valid, req_ready} == 8'b11111001,
          "R1 outputs during reset",
          32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rd_valid, req_ready}), 32'hF9);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rd_valid, req_ready} == 8'b11111001,
          "R1 outputs after reset",
          32'({mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n, mem_dq_oe, rd_valid, req_ready}), 32'hF9);

      // full-word writes over every start offset and length
      for (int st = 0; st < 8; st++)
         for (int ln = 0; ln < 8; ln++)
            xact(1'b1, {16'h02A5, 4'(st + ln), 3'(st)}, ln, 2'b11);
      // read back every start offset and length
      for (int st = 0; st < 8; st++)
         for (int ln = 0; ln < 8; ln++)
            xact(1'b0, {16'h02A5, 4'(st + 2 * ln), 3'(7 - st)}, ln, 2'b11);
      // single-lane writes, lower then upper (R8)
      for (int pg = 0; pg < 4; pg++) begin
         xact(1'b1, {16'h02A5, 4'(pg), 3'(pg)}, 2 * pg + 1, 2'b01);
         xact(1'b1, {16'h02A5, 4'(pg), 3'(pg + 3)}, 2 * pg, 2'b10);
      end
      // read-back through single lanes
      for (int pg = 0; pg < 4; pg++) begin
         xact(1'b0, {16'h02A5, 4'(pg), 3'd0}, 7, 2'b01);
         xact(1'b0, {16'h02A5, 4'(pg), 3'd4}, 7, 2'b10);
      end
      repeat (4) @(negedge clk);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R2 watchdog expired actual=busy expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule